// File: doc/BRIEF.md
# Processor Status Word with Exception-Entry Control

This block holds the 32-bit status word of a processor core and changes it when software writes it, when an interrupt is taken and when an exception is entered. The status word carries a privilege flag, a register-bank select flag, an exception-block flag, a floating-point disable flag, four single-bit arithmetic and condition flags, and a 4-bit interrupt mask level. Bits that carry no field always read as zero.

Entering an exception or taking an interrupt sets the privilege, bank and block flags together in one cycle. While the block flag is set, every interrupt is masked. A general exception, other than a user break, that arrives while the block flag is set does not enter normally. It moves the block into a fault state that asserts a request to enter the reset state. That request stays asserted until the next reset. A small state machine tracks whether interrupts are open, blocked or faulted. A priority arbiter picks at most one event per cycle.

Top module: `psr_status_ctrl`

States: `ST_OPEN` (block flag 0), `ST_BLOCKED` (block flag 1), `ST_FAULT` (reset requested). Transitions: OPEN→BLOCKED on an interrupt entry, an exception entry, or a write with bit 28 set. BLOCKED→OPEN on a write with bit 28 clear. BLOCKED→BLOCKED on a user-break exception. BLOCKED→FAULT on a non-user-break exception. FAULT is left only by reset.

## Requirements
- R1: After reset, `status_word` is 32'h7000_00F0 and `reset_req` is 0. The set bits are bits 30, 29 and 28 (privilege, bank, block) and mask level 4'b1111 in bits 7:4.
- R2: Bits 31, 27:16, 14:10 and 3:2 of `status_word` always read 0. Writing 1 to them changes nothing.
- R3: A write (`sw_we`=1), with no other event in that cycle, loads the writable bits from `sw_wdata` at the next clock edge. The writable bits are those of mask 32'h7000_83F3: bit 30 privilege, 29 bank, 28 block, 15 FPU disable, 9 and 8 flags, 7:4 mask level, 1 and 0 flags. The other bits keep their values.
- R4: `exc_entry` while the block flag is 0, or while `exc_ubreak` is 1, sets bits 30, 29 and 28 to 1 at the next edge. All other bits keep their values.
- R5: `int_accept` sets bits 30, 29 and 28 to 1 at the next edge when `int_masked` is 0. It has no effect when `int_masked` is 1.
- R6: `int_masked` is 0 only when the block flag is 0 and `int_level` is strictly greater than the mask level in bits 7:4. It is combinational from the inputs.
- R7: `exc_entry` with `exc_ubreak`=0 while the block flag is 1 leaves `status_word` unchanged and raises `reset_req` at the next edge.
- R8: Once `reset_req` is 1, it stays 1 until reset. In that state, writes, exceptions and interrupts leave `status_word` unchanged.
- R9: Events in one cycle are served in this priority order: exception entry, then interrupt entry, then software write. The losing events are discarded.
- R10: `mode_priv`, `bank_sel`, `block_flag` and `imask` equal bits 30, 29, 28 and 7:4 of `status_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| exc_entry | input | 1 | General exception entry strobe |
| exc_ubreak | input | 1 | Marks the exception as a user break |
| int_accept | input | 1 | Interrupt entry strobe |
| int_level | input | 4 | Level of the pending interrupt request |
| status_word | output | 32 | Current status word |
| mode_priv | output | 1 | 1 = privileged, 0 = user |
| bank_sel | output | 1 | Register bank select |
| block_flag | output | 1 | Exception/interrupt block flag |
| imask | output | 4 | Interrupt mask level |
| int_masked | output | 1 | The pending interrupt would be refused |
| reset_req | output | 1 | Request to enter the reset state |

## Verification
The write path is driven with a walking one across all 32 bits and with dense and alternating patterns. This separates writable bits from reserved ones and shows which flag moves the machine between the open and blocked states. The masking rule is swept over every pairing of mask level and request level, with the block flag both clear and set. This pins down the strict comparison at equal levels. Simultaneous events are combined in pairs and triples to show the priority order. Exceptions with and without the user-break class are applied in the blocked state, to separate a normal re-entry from the fault state and its stickiness.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int WORD_W    = 32;
    localparam int IMASK_W   = 4;
    localparam int IMASK_LSB = 4;
    localparam int IMASK_MSB = IMASK_LSB + IMASK_W - 1;

    localparam int MD_BIT = 30;
    localparam int RB_BIT = 29;
    localparam int BL_BIT = 28;
    localparam int FD_BIT = 15;
    localparam int M_BIT  = 9;
    localparam int Q_BIT  = 8;
    localparam int S_BIT  = 1;
    localparam int T_BIT  = 0;

    localparam logic [WORD_W-1:0] WR_MASK    = 32'h7000_83F3;
    localparam logic [WORD_W-1:0] RESET_WORD = 32'h7000_00F0;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_WRITE,
        EV_INT,
        EV_EXC,
        EV_FATAL
    } psr_event_e;

    typedef enum logic [1:0] {
        ST_OPEN,
        ST_BLOCKED,
        ST_FAULT
    } psr_state_e;

    typedef struct packed {
        logic               md;
        logic               rb;
        logic               fd;
        logic               m;
        logic               q;
        logic [IMASK_W-1:0] imask;
        logic               s;
        logic               t;
    } psr_fields_t;

endpackage

// File: rtl/psr_event_arb.sv
module psr_event_arb
    import psr_pkg::*;
(
    input  logic               fault,
    input  logic               bl,
    input  logic [IMASK_W-1:0] imask,
    input  logic [IMASK_W-1:0] int_level,
    input  logic               exc_entry,
    input  logic               exc_ubreak,
    input  logic               int_accept,
    input  logic               sw_we,
    output psr_event_e         ev,
    output logic               int_masked
);

    logic level_above;

    always_comb begin
        level_above = (int_level > imask);
        int_masked  = bl || !level_above;
    end

    always_comb begin
        ev = EV_NONE;
        if (fault) begin
            ev = EV_NONE;
        end else if (exc_entry) begin
            if (bl && !exc_ubreak) begin
                ev = EV_FATAL;
            end else begin
                ev = EV_EXC;
            end
        end else if (int_accept && !int_masked) begin
            ev = EV_INT;
        end else if (sw_we) begin
            ev = EV_WRITE;
        end
    end

endmodule

// File: rtl/psr_block_fsm.sv
module psr_block_fsm
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  psr_event_e ev,
    input  logic       wr_bl,
    output psr_state_e state,
    output logic       bl,
    output logic       fault
);

    psr_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BLOCKED;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN: begin
                case (ev)
                    EV_WRITE: state_nxt = wr_bl ? ST_BLOCKED : ST_OPEN;
                    EV_INT:   state_nxt = ST_BLOCKED;
                    EV_EXC:   state_nxt = ST_BLOCKED;
                    default:  state_nxt = ST_OPEN;
                endcase
            end
            ST_BLOCKED: begin
                case (ev)
                    EV_WRITE: state_nxt = wr_bl ? ST_BLOCKED : ST_OPEN;
                    EV_EXC:   state_nxt = ST_BLOCKED;
                    EV_FATAL: state_nxt = ST_FAULT;
                    default:  state_nxt = ST_BLOCKED;
                endcase
            end
            ST_FAULT: begin
                state_nxt = ST_FAULT;
            end
            default: begin
                state_nxt = ST_FAULT;
            end
        endcase
    end

    always_comb begin
        bl    = 1'b1;
        fault = 1'b0;
        unique case (state)
            ST_OPEN:    bl = 1'b0;
            ST_BLOCKED: bl = 1'b1;
            ST_FAULT: begin
                bl    = 1'b1;
                fault = 1'b1;
            end
            default: begin
                bl    = 1'b1;
                fault = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/psr_field_reg.sv
module psr_field_reg
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  psr_event_e        ev,
    input  logic [WORD_W-1:0] wdata,
    output psr_fields_t       fields
);

    psr_fields_t fields_nxt;
    psr_fields_t wr_fields;

    always_comb begin
        wr_fields.md    = wdata[MD_BIT];
        wr_fields.rb    = wdata[RB_BIT];
        wr_fields.fd    = wdata[FD_BIT];
        wr_fields.m     = wdata[M_BIT];
        wr_fields.q     = wdata[Q_BIT];
        wr_fields.imask = wdata[IMASK_MSB:IMASK_LSB];
        wr_fields.s     = wdata[S_BIT];
        wr_fields.t     = wdata[T_BIT];
    end

    always_comb begin
        fields_nxt = fields;
        case (ev)
            EV_WRITE: fields_nxt = wr_fields;
            EV_INT, EV_EXC: begin
                fields_nxt.md = 1'b1;
                fields_nxt.rb = 1'b1;
            end
            default: fields_nxt = fields;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields.md    <= 1'b1;
            fields.rb    <= 1'b1;
            fields.fd    <= 1'b0;
            fields.m     <= 1'b0;
            fields.q     <= 1'b0;
            fields.imask <= '1;
            fields.s     <= 1'b0;
            fields.t     <= 1'b0;
        end else begin
            fields <= fields_nxt;
        end
    end

endmodule

// File: rtl/psr_status_ctrl.sv
module psr_status_ctrl
    import psr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_we,
    input  logic [WORD_W-1:0]  sw_wdata,
    input  logic               exc_entry,
    input  logic               exc_ubreak,
    input  logic               int_accept,
    input  logic [IMASK_W-1:0] int_level,
    output logic [WORD_W-1:0]  status_word,
    output logic               mode_priv,
    output logic               bank_sel,
    output logic               block_flag,
    output logic [IMASK_W-1:0] imask,
    output logic               int_masked,
    output logic               reset_req
);

    psr_event_e  ev;
    psr_state_e  state;
    psr_fields_t fields;
    logic        bl;
    logic        fault;

    psr_event_arb u_arb (
        .fault      (fault),
        .bl         (bl),
        .imask      (fields.imask),
        .int_level  (int_level),
        .exc_entry  (exc_entry),
        .exc_ubreak (exc_ubreak),
        .int_accept (int_accept),
        .sw_we      (sw_we),
        .ev         (ev),
        .int_masked (int_masked)
    );

    psr_block_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .wr_bl (sw_wdata[BL_BIT]),
        .state (state),
        .bl    (bl),
        .fault (fault)
    );

    psr_field_reg u_fields (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .wdata  (sw_wdata),
        .fields (fields)
    );

    always_comb begin
        status_word                       = '0;
        status_word[MD_BIT]               = fields.md;
        status_word[RB_BIT]               = fields.rb;
        status_word[BL_BIT]               = bl;
        status_word[FD_BIT]               = fields.fd;
        status_word[M_BIT]                = fields.m;
        status_word[Q_BIT]                = fields.q;
        status_word[IMASK_MSB:IMASK_LSB]  = fields.imask;
        status_word[S_BIT]                = fields.s;
        status_word[T_BIT]                = fields.t;
    end

    always_comb begin
        mode_priv  = fields.md;
        bank_sel   = fields.rb;
        block_flag = bl;
        imask      = fields.imask;
        reset_req  = fault;
    end

endmodule

// File: rtl/psr_status_chk.sv
module psr_status_chk
    import psr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               exc_entry,
    input logic               exc_ubreak,
    input logic               int_accept,
    input logic [WORD_W-1:0]  status_word,
    input logic               mode_priv,
    input logic               bank_sel,
    input logic               block_flag,
    input logic               int_masked,
    input logic               reset_req
);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~WR_MASK) == '0);

    assert_entry_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && !reset_req && (!block_flag || exc_ubreak))
        |=> (mode_priv && bank_sel && block_flag));

    assert_int_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_accept && !int_masked && !exc_entry && !reset_req)
        |=> (mode_priv && bank_sel && block_flag));

    assert_block_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        block_flag |-> int_masked);

    assert_fatal_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && !exc_ubreak && block_flag && !reset_req)
        |=> (reset_req && status_word == $past(status_word)));

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (reset_req && $stable(status_word)));

endmodule

bind psr_status_ctrl psr_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_entry   (exc_entry),
    .exc_ubreak  (exc_ubreak),
    .int_accept  (int_accept),
    .status_word (status_word),
    .mode_priv   (mode_priv),
    .bank_sel    (bank_sel),
    .block_flag  (block_flag),
    .int_masked  (int_masked),
    .reset_req   (reset_req)
);

// File: tb/tb_psr_status_ctrl.sv
`timescale 1ns/1ps
module tb_psr_status_ctrl;

    localparam logic [31:0] MASK  = 32'h7000_83F3;
    localparam logic [31:0] RST_W = 32'h7000_00F0;
    localparam logic [31:0] ENTRY = 32'h7000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        exc_entry = 1'b0;
    logic        exc_ubreak = 1'b0;
    logic        int_accept = 1'b0;
    logic [3:0]  int_level = '0;
    logic [31:0] status_word;
    logic        mode_priv;
    logic        bank_sel;
    logic        block_flag;
    logic [3:0]  imask;
    logic        int_masked;
    logic        reset_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] exp_word;
    logic        exp_fault;

    always #2.5 clk = ~clk;

    psr_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .exc_entry(exc_entry), .exc_ubreak(exc_ubreak), .int_accept(int_accept),
        .int_level(int_level), .status_word(status_word), .mode_priv(mode_priv),
        .bank_sel(bank_sel), .block_flag(block_flag), .imask(imask),
        .int_masked(int_masked), .reset_req(reset_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_outputs(input string tag);
        chk(tag, status_word, exp_word);
        chk(tag, {31'd0, reset_req}, {31'd0, exp_fault});
        chk("R10", {28'd0, mode_priv, bank_sel, block_flag, 1'b0},
            {28'd0, exp_word[30], exp_word[29], exp_word[28], 1'b0});
        chk("R10", {28'd0, imask}, {28'd0, exp_word[7:4]});
    endtask

    // Applies one cycle of stimulus, updates the model from the requirements, checks after the edge.
    task automatic cycle(input string tag, input logic we, input logic [31:0] wd,
                         input logic exc, input logic ub, input logic ia, input logic [3:0] lvl);
        logic bl_now;
        logic masked_now;
        sw_we = we; sw_wdata = wd; exc_entry = exc; exc_ubreak = ub;
        int_accept = ia; int_level = lvl;
        bl_now     = exp_word[28];
        masked_now = bl_now || (lvl <= exp_word[7:4]);
        if (exp_fault) begin
            exp_word = exp_word;
        end else if (exc) begin
            if (bl_now && !ub) exp_fault = 1'b1;
            else               exp_word  = exp_word | ENTRY;
        end else if (ia && !masked_now) begin
            exp_word = exp_word | ENTRY;
        end else if (we) begin
            exp_word = (exp_word & ~MASK) | (wd & MASK);
        end
        @(posedge clk);
        #1;
        sw_we = 1'b0; exc_entry = 1'b0; exc_ubreak = 1'b0; int_accept = 1'b0;
        chk_outputs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        exp_word  = RST_W;
        exp_fault = 1'b0;
        @(posedge clk);
        #1;
        chk_outputs("R1");
    endtask

    initial begin
        do_reset();

        // R2 / R3: walking one across every bit, with a clear between.
        for (int i = 0; i < 32; i++) begin
            cycle("R3", 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 4'd0);
            cycle("R2", 1'b1, 32'h1 << i, 1'b0, 1'b0, 1'b0, 4'd0);
        end
        cycle("R2", 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R3", 1'b1, 32'hA5A5_A5A5, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R3", 1'b1, 32'h5A5A_5A5A, 1'b0, 1'b0, 1'b0, 4'd0);

        // R6: every mask level against every request level, block flag clear and set.
        for (int im = 0; im < 16; im++) begin
            cycle("R3", 1'b1, 32'(im) << 4, 1'b0, 1'b0, 1'b0, 4'd0);
            for (int lv = 0; lv < 16; lv++) begin
                int_level = 4'(lv);
                #0.2;
                chk("R6", {31'd0, int_masked}, {31'd0, (lv <= im)});
            end
            cycle("R3", 1'b1, 32'h1000_0000 | (32'(im) << 4), 1'b0, 1'b0, 1'b0, 4'd0);
            for (int lv = 0; lv < 16; lv++) begin
                int_level = 4'(lv);
                #0.2;
                chk("R6", {31'd0, int_masked}, 32'd1);
            end
        end

        // R5: interrupt refused at or below mask, taken above it.
        cycle("R3", 1'b1, 32'h0000_8331, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R5", 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd2);
        cycle("R5", 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd3);
        cycle("R5", 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd4);
        cycle("R5", 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd15);

        // R4 / R9: exception beats a write and an interrupt in the same cycle.
        cycle("R3", 1'b1, 32'h0000_0102, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R9", 1'b1, 32'h0000_00F3, 1'b1, 1'b0, 1'b1, 4'd9);
        cycle("R3", 1'b1, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R4", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 4'd0);

        // R4: user-break exception while blocked re-enters normally.
        cycle("R4", 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 4'd0);

        // R9: interrupt beats a write; masked interrupt lets the write through.
        cycle("R3", 1'b1, 32'h0000_0020, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R9", 1'b1, 32'h0000_80C0, 1'b0, 1'b0, 1'b1, 4'd7);
        cycle("R3", 1'b1, 32'h0000_0050, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R9", 1'b1, 32'h0000_0303, 1'b0, 1'b0, 1'b1, 4'd5);

        // R7 / R8: non-user-break exception while blocked faults; fault is sticky.
        cycle("R3", 1'b1, 32'h1000_0003, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R7", 1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'd0);
        cycle("R8", 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'd0);
        cycle("R8", 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 4'd0);
        cycle("R8", 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd15);
        cycle("R8", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd0);

        do_reset();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule